// File: doc/BRIEF.md
# Register-Mapped Frame Mailbox

The block gives a processor byte-by-byte access to one inbound and one outbound network frame through a small register window. A 6-bit address selects a register. Reads and writes take effect on the clock edge. Read data is presented combinationally while the read strobe is high. The inbound side takes a whole frame as a byte stream with valid, last and ready. Software then drains the frame by reading one data register over and over, and each read lowers the byte count by one.

On the outbound side, software first writes the frame length and then writes the bytes one at a time. The write that fills the last byte hands the frame to the sender, which holds a valid and a length until it acknowledges. The sender fetches the stored bytes through a peek port. A single busy flag controls whether a new inbound frame may start. Both completions set it. A separate interrupt block can load it, and that block also receives the one-cycle rx_done and tx_done pulses.

Top module: `frame_mailbox`

## Requirements
- R1: After reset, busy is 1, both byte counts are 0, tx_fvalid is 0 and every stored outbound byte reads 0 on the peek port, including bytes written before the reset.
- R2: Offset 0x00 reads parameter ID_HI and offset 0x04 reads parameter ID_LO. Offsets 0x14, 0x18 and 0x20 read 0, as does every offset outside the map.
- R3: rx_ready is high between frames only while busy is 0 and the inbound count is below DEPTH. Once the first byte of a frame is taken, rx_ready stays high until the byte marked last.
- R4: An accepted frame is stored from index 0. On the edge that takes its last byte, the inbound count (offset 0x0C) becomes the frame length and busy becomes 1. rx_done is 1 for exactly the following cycle.
- R5: Each read of offset 0x1C returns the next stored byte in arrival order and lowers the inbound count by one. With the count at 0 the read returns 0 and changes nothing.
- R6: A write to offset 0x10 stores the value as the outbound length if it is at most DEPTH, and stores 0 otherwise. Either way the write pointer returns to index 0.
- R7: Each write to offset 0x20 stores bits 7:0 at the write pointer and advances it. When the pointer reaches the outbound length, tx_fvalid rises with tx_flen equal to that length, the outbound count returns to 0, busy becomes 1, and tx_done is 1 for exactly one cycle.
- R8: tx_fvalid and tx_flen hold until tx_fack is sampled high.
- R9: busy_ld loads busy_ld_val into busy (read at offset 0x08, bit 0). A frame completion in the same cycle takes priority and leaves busy at 1.
- R10: Writes to offsets 0x0C, 0x08 and 0x1C change no state.
- R11: Bytes of an inbound frame beyond DEPTH are discarded, and the count becomes DEPTH. No new frame is accepted until a read lowers the count, even when busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a read of 0x1C pops a byte) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| busy_ld | input | 1 | Load strobe for busy from the interrupt block |
| busy_ld_val | input | 1 | Value loaded into busy |
| busy | output | 1 | Busy flag |
| rx_valid | input | 1 | Inbound byte valid |
| rx_byte | input | 8 | Inbound byte |
| rx_last | input | 1 | Marks the last byte of a frame |
| rx_ready | output | 1 | Inbound byte accepted at this edge |
| rx_done | output | 1 | One-cycle pulse after a frame is stored |
| tx_fvalid | output | 1 | Outbound frame ready for the sender |
| tx_flen | output | CW | Outbound frame length |
| tx_fack | input | 1 | Sender has taken the frame |
| tx_peek_addr | input | AW | Outbound byte index for the sender |
| tx_peek_byte | output | 8 | Outbound byte at tx_peek_addr |
| tx_done | output | 1 | One-cycle pulse after a frame is handed off |

## Verification
The hardest state to reach is a full inbound buffer with busy cleared. Reaching it needs an oversize frame first, followed by a load of busy to 0. Only then does the count limit alone hold rx_ready low. The bench reaches it with a bench depth of 8 and a stream of 11 bytes. It clears busy through the load input and checks that rx_ready stays low. It then pops one byte and checks that rx_ready rises. A second hard case is a frame completion that lands in the same cycle as a busy load of 0. The bench lines up the final outbound byte write with that load.

// File: rtl/frame_mailbox_pkg.sv
package frame_mailbox_pkg;

  localparam logic [5:0] OFS_ID_HI   = 6'h00;
  localparam logic [5:0] OFS_ID_LO   = 6'h04;
  localparam logic [5:0] OFS_BUSY    = 6'h08;
  localparam logic [5:0] OFS_RX_CNT  = 6'h0C;
  localparam logic [5:0] OFS_TX_CNT  = 6'h10;
  localparam logic [5:0] OFS_IRQ_CTL = 6'h14;
  localparam logic [5:0] OFS_IRQ_INF = 6'h18;
  localparam logic [5:0] OFS_RX_DATA = 6'h1C;
  localparam logic [5:0] OFS_TX_DATA = 6'h20;

  // a requested length above the buffer depth collapses to zero
  function automatic logic [31:0] fit_len(input logic [31:0] v, input int unsigned lim);
    return (v <= lim) ? v : 32'd0;
  endfunction

  // index step that stops at the buffer depth
  function automatic logic [31:0] sat_step(input logic [31:0] idx, input int unsigned lim);
    return (idx < lim) ? idx + 32'd1 : idx;
  endfunction

endpackage

// File: rtl/fm_rx_store.sv
module fm_rx_store
  import frame_mailbox_pkg::*;
#(
  parameter int DEPTH = 1514,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          pop,
  output logic [CW-1:0] count,
  output logic [7:0]    head_byte,
  output logic          fin,
  output logic          done
);

  logic [7:0]    mem [DEPTH];
  logic          filling;
  logic [CW-1:0] fill_idx, rd_ptr;
  logic [CW-1:0] slot, slot_next;
  logic          take, pop_ok, slot_fits;

  assign in_ready  = filling | (~busy & (count < CW'(DEPTH)));
  assign take      = in_valid & in_ready;
  assign slot      = filling ? fill_idx : '0;
  assign slot_fits = slot < CW'(DEPTH);
  assign slot_next = CW'(sat_step(32'(slot), DEPTH));
  assign fin       = take & in_last;
  assign pop_ok    = pop & (count != '0);
  assign head_byte = (count != '0) ? mem[rd_ptr[AW-1:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      filling  <= 1'b0;
      fill_idx <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      done     <= 1'b0;
    end else begin
      done <= fin;
      if (take && slot_fits) mem[slot[AW-1:0]] <= in_byte;
      if (take) begin
        if (in_last) begin
          filling  <= 1'b0;
          fill_idx <= '0;
        end else begin
          filling  <= 1'b1;
          fill_idx <= slot_next;
        end
      end
      if (fin) begin
        count  <= slot_next;
        rd_ptr <= '0;
      end else if (pop_ok) begin
        count  <= count - 1'b1;
        rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end

  // R11
  rx_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R5
  rx_pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !fin) |=> count == $past(count) - 1'b1);

  // R10
  rx_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop && !fin) |=> $stable(count));

endmodule

// File: rtl/fm_tx_store.sv
module fm_tx_store
  import frame_mailbox_pkg::*;
#(
  parameter int DEPTH = 1514,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_len,
  input  logic [31:0]   len_val,
  input  logic          push,
  input  logic [7:0]    push_byte,
  output logic [CW-1:0] count,
  output logic          fin,
  output logic          done,
  output logic          out_valid,
  output logic [CW-1:0] out_len,
  input  logic          out_ack,
  input  logic [AW-1:0] peek_addr,
  output logic [7:0]    peek_byte
);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] wr_ptr, ptr_next;
  logic          ptr_fits;

  assign ptr_fits  = wr_ptr < CW'(DEPTH);
  assign ptr_next  = CW'(sat_step(32'(wr_ptr), DEPTH));
  assign fin       = push & (ptr_next == count);
  assign peek_byte = (32'(peek_addr) < DEPTH) ? mem[peek_addr] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      wr_ptr    <= '0;
      count     <= '0;
      done      <= 1'b0;
      out_valid <= 1'b0;
      out_len   <= '0;
    end else begin
      done <= fin;
      if (push && ptr_fits) mem[wr_ptr[AW-1:0]] <= push_byte;
      if (set_len) begin
        count  <= CW'(fit_len(len_val, DEPTH));
        wr_ptr <= '0;
      end else if (fin) begin
        count  <= '0;
        wr_ptr <= '0;
      end else if (push) begin
        wr_ptr <= ptr_next;
      end
      if (fin) begin
        out_valid <= 1'b1;
        out_len   <= count;
      end else if (out_ack) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R7
  tx_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> out_valid && done && count == '0 && out_len == $past(count));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ack && !fin) |=> out_valid && $stable(out_len));

  // R6
  tx_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/frame_mailbox.sv
module frame_mailbox
  import frame_mailbox_pkg::*;
#(
  parameter int          DEPTH = 1514,
  parameter logic [31:0] ID_HI = 32'h4642_5546,
  parameter logic [31:0] ID_LO = 32'h5052_5430,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          busy_ld,
  input  logic          busy_ld_val,
  output logic          busy,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          rx_last,
  output logic          rx_ready,
  output logic          rx_done,
  output logic          tx_fvalid,
  output logic [CW-1:0] tx_flen,
  input  logic          tx_fack,
  input  logic [AW-1:0] tx_peek_addr,
  output logic [7:0]    tx_peek_byte,
  output logic          tx_done
);

  logic          rx_pop, tx_set_len, tx_push;
  logic          rx_fin, tx_fin;
  logic [CW-1:0] rx_count, tx_count;
  logic [7:0]    rx_head;
  logic          busy_q;

  assign rx_pop     = bus_rd & (bus_addr == OFS_RX_DATA);
  assign tx_set_len = bus_wr & (bus_addr == OFS_TX_CNT);
  assign tx_push    = bus_wr & (bus_addr == OFS_TX_DATA);

  fm_rx_store #(.DEPTH(DEPTH)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_q),
    .in_valid  (rx_valid),
    .in_byte   (rx_byte),
    .in_last   (rx_last),
    .in_ready  (rx_ready),
    .pop       (rx_pop),
    .count     (rx_count),
    .head_byte (rx_head),
    .fin       (rx_fin),
    .done      (rx_done)
  );

  fm_tx_store #(.DEPTH(DEPTH)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_len   (tx_set_len),
    .len_val   (bus_wdata),
    .push      (tx_push),
    .push_byte (bus_wdata[7:0]),
    .count     (tx_count),
    .fin       (tx_fin),
    .done      (tx_done),
    .out_valid (tx_fvalid),
    .out_len   (tx_flen),
    .out_ack   (tx_fack),
    .peek_addr (tx_peek_addr),
    .peek_byte (tx_peek_byte)
  );

  // completion of either frame wins over a load from the interrupt block
  always_ff @(posedge clk) begin
    if (!rst_n)                busy_q <= 1'b1;
    else if (rx_fin || tx_fin) busy_q <= 1'b1;
    else if (busy_ld)          busy_q <= busy_ld_val;
  end
  assign busy = busy_q;

  always_comb begin
    unique case (bus_addr)
      OFS_ID_HI:   bus_rdata = ID_HI;
      OFS_ID_LO:   bus_rdata = ID_LO;
      OFS_BUSY:    bus_rdata = {31'd0, busy_q};
      OFS_RX_CNT:  bus_rdata = 32'(rx_count);
      OFS_TX_CNT:  bus_rdata = 32'(tx_count);
      OFS_RX_DATA: bus_rdata = {24'd0, rx_head};
      default:     bus_rdata = 32'd0;
    endcase
  end

  // R4 R9
  busy_on_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fin || tx_fin) |=> busy_q);

  // R9
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_ld && !rx_fin && !tx_fin) |=> busy_q == $past(busy_ld_val));

endmodule

// File: tb/test_frame_mailbox.sv
module test_frame_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);
  localparam logic [31:0] ID_HI = 32'h4642_5546;
  localparam logic [31:0] ID_LO = 32'h5052_5430;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          busy_ld = 1'b0, busy_ld_val = 1'b0, busy;
  logic          rx_valid = 1'b0, rx_last = 1'b0, rx_ready, rx_done;
  logic [7:0]    rx_byte = '0;
  logic          tx_fvalid, tx_fack = 1'b0, tx_done;
  logic [CW-1:0] tx_flen;
  logic [AW-1:0] tx_peek_addr = '0;
  logic [7:0]    tx_peek_byte;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  frame_mailbox #(.DEPTH(DEPTH), .ID_HI(ID_HI), .ID_LO(ID_LO)) i_frame_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_ld(busy_ld),
    .busy_ld_val(busy_ld_val), .busy(busy), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_last(rx_last), .rx_ready(rx_ready), .rx_done(rx_done), .tx_fvalid(tx_fvalid),
    .tx_flen(tx_flen), .tx_fack(tx_fack), .tx_peek_addr(tx_peek_addr),
    .tx_peek_byte(tx_peek_byte), .tx_done(tx_done)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic load_busy(input logic v);
    @(negedge clk);
    busy_ld = 1'b1; busy_ld_val = v;
    @(negedge clk);
    busy_ld = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = base + 8'(i); rx_last = (i == n - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic ack_frame();
    @(negedge clk); tx_fack = 1'b1;
    @(negedge clk); tx_fack = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(6'h08, d); check("R1", "busy after reset", d, 32'd1);
    bus_read(6'h0C, d); check("R1", "rx count after reset", d, 32'd0);
    bus_read(6'h10, d); check("R1", "tx count after reset", d, 32'd0);
    check("R1", "tx_fvalid after reset", {31'd0, tx_fvalid}, 32'd0);
    tx_peek_addr = 3'd3; #1;
    check("R1", "tx byte after reset", {24'd0, tx_peek_byte}, 32'd0);
    check("R3", "rx_ready while busy", {31'd0, rx_ready}, 32'd0);
  endtask

  task automatic t_ids();
    logic [31:0] d;
    bus_read(6'h00, d); check("R2", "id high", d, ID_HI);
    bus_read(6'h04, d); check("R2", "id low", d, ID_LO);
    bus_read(6'h14, d); check("R2", "0x14 reads zero", d, 32'd0);
    bus_read(6'h18, d); check("R2", "0x18 reads zero", d, 32'd0);
    bus_read(6'h20, d); check("R2", "0x20 reads zero", d, 32'd0);
    bus_read(6'h3C, d); check("R2", "unmapped reads zero", d, 32'd0);
  endtask

  task automatic t_busy_load();
    logic [31:0] d;
    load_busy(1'b0);
    bus_read(6'h08, d); check("R9", "busy loaded to 0", d, 32'd0);
    check("R3", "rx_ready when idle", {31'd0, rx_ready}, 32'd1);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    send_frame(5, 8'h30);
    check("R4", "rx_done pulse", {31'd0, rx_done}, 32'd1);
    check("R4", "busy after frame", {31'd0, busy}, 32'd1);
    check("R3", "rx_ready after frame", {31'd0, rx_ready}, 32'd0);
    @(negedge clk);
    check("R4", "rx_done one cycle", {31'd0, rx_done}, 32'd0);
    bus_read(6'h0C, d); check("R4", "rx count = length", d, 32'd5);
    bus_write(6'h0C, 32'd2);
    bus_write(6'h08, 32'd0);
    bus_write(6'h1C, 32'd0);
    bus_read(6'h0C, d); check("R10", "rx count unchanged by writes", d, 32'd5);
    bus_read(6'h08, d); check("R10", "busy unchanged by write", d, 32'd1);
    for (int i = 0; i < 5; i++) begin
      bus_read(6'h1C, d); check("R5", "rx data byte", d, 32'h30 + 32'(i));
    end
    bus_read(6'h0C, d); check("R5", "rx count drained", d, 32'd0);
    bus_read(6'h1C, d); check("R5", "empty read returns 0", d, 32'd0);
    bus_read(6'h0C, d); check("R5", "empty read leaves count", d, 32'd0);
  endtask

  task automatic t_tx();
    logic [31:0] d;
    bus_write(6'h10, 32'd3);
    bus_read(6'h10, d); check("R6", "tx count stored", d, 32'd3);
    bus_write(6'h20, 32'h1AB);
    bus_write(6'h20, 32'h2CD);
    check("R7", "no handoff before last byte", {31'd0, tx_fvalid}, 32'd0);
    bus_write(6'h20, 32'h3EF);
    check("R7", "tx_done pulse", {31'd0, tx_done}, 32'd1);
    check("R7", "tx_fvalid", {31'd0, tx_fvalid}, 32'd1);
    check("R7", "tx_flen", 32'(tx_flen), 32'd3);
    tx_peek_addr = 3'd0; #1; check("R7", "byte 0", {24'd0, tx_peek_byte}, 32'hAB);
    tx_peek_addr = 3'd1; #1; check("R7", "byte 1", {24'd0, tx_peek_byte}, 32'hCD);
    tx_peek_addr = 3'd2; #1; check("R7", "byte 2", {24'd0, tx_peek_byte}, 32'hEF);
    bus_read(6'h10, d); check("R7", "tx count cleared", d, 32'd0);
    check("R7", "tx_done one cycle", {31'd0, tx_done}, 32'd0);
    bus_read(6'h08, d); check("R7", "busy after send", d, 32'd1);
    repeat (2) @(negedge clk);
    check("R8", "tx_fvalid held", {31'd0, tx_fvalid}, 32'd1);
    check("R8", "tx_flen held", 32'(tx_flen), 32'd3);
    ack_frame();
    check("R8", "tx_fvalid after ack", {31'd0, tx_fvalid}, 32'd0);
  endtask

  task automatic t_tx_len();
    logic [31:0] d;
    bus_write(6'h10, DEPTH + 1);
    bus_read(6'h10, d); check("R6", "oversize length stores 0", d, 32'd0);
    bus_write(6'h10, DEPTH);
    bus_read(6'h10, d); check("R6", "length at depth", d, DEPTH);
    bus_write(6'h10, 32'd2);
    bus_write(6'h20, 32'h11);
    bus_write(6'h10, 32'd2);
    bus_write(6'h20, 32'h22);
    check("R6", "pointer reset delays handoff", {31'd0, tx_fvalid}, 32'd0);
    bus_write(6'h20, 32'h33);
    check("R6", "handoff after rewrite", {31'd0, tx_done}, 32'd1);
    tx_peek_addr = 3'd0; #1; check("R6", "restart at index 0", {24'd0, tx_peek_byte}, 32'h22);
    ack_frame();
  endtask

  task automatic t_busy_prio();
    logic [31:0] d;
    bus_write(6'h10, 32'd1);
    @(negedge clk);
    bus_addr = 6'h20; bus_wdata = 32'h5A; bus_wr = 1'b1;
    busy_ld = 1'b1; busy_ld_val = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0; busy_ld = 1'b0;
    check("R9", "completion beats busy load", {31'd0, busy}, 32'd1);
    check("R7", "single byte frame done", {31'd0, tx_done}, 32'd1);
    bus_read(6'h08, d); check("R9", "busy reg", d, 32'd1);
    ack_frame();
  endtask

  task automatic t_oversize();
    logic [31:0] d;
    load_busy(1'b0);
    send_frame(DEPTH + 3, 8'h60);
    check("R11", "rx_done on oversize", {31'd0, rx_done}, 32'd1);
    bus_read(6'h0C, d); check("R11", "count capped at depth", d, DEPTH);
    load_busy(1'b0);
    check("R11", "full buffer refuses", {31'd0, rx_ready}, 32'd0);
    bus_read(6'h1C, d); check("R11", "first kept byte", d, 32'h60);
    check("R3", "ready once below depth", {31'd0, rx_ready}, 32'd1);
    for (int i = 1; i < DEPTH; i++) bus_read(6'h1C, d);
    check("R11", "last kept byte", d, 32'h60 + DEPTH - 1);
  endtask

  task automatic t_reset_clear();
    apply_reset();
    tx_peek_addr = 3'd0; #1;
    check("R1", "stored byte cleared by reset", {24'd0, tx_peek_byte}, 32'd0);
    check("R1", "busy after second reset", {31'd0, busy}, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ids();
    t_busy_load();
    t_rx();
    t_tx();
    t_tx_len();
    t_busy_prio();
    t_oversize();
    t_reset_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule